// File: doc/BRIEF.md
# Per-Core Interrupt Router

This block gathers the interrupt sources of a four-core cluster and steers each of them to one core's normal interrupt line (IRQ) or fast interrupt line (FIQ). Every core has four timer inputs and four mailbox inputs of its own. A single GPU line and a single PMU line are shared by all cores. Per-core control words decide, bit by bit, whether a timer or mailbox source is masked, sent to IRQ or sent to FIQ. A routing word picks the core that receives the GPU line. A per-core enable mask gates the PMU line, and software changes that mask only through separate set and clear addresses.

Software reads a 10-bit IRQ-pending word and a 10-bit FIQ-pending word for each core through a simple register port. In both words, bits 0-3 hold timers 0-3, bits 4-7 hold mailboxes 0-3, bit 8 holds the GPU and bit 9 holds the PMU. The pending words and the two output lines per core are registered. A level on a source input is therefore visible one clock after the edge that samples it.

Top module: `core_irq_router`

## Requirements
- R1: After a synchronous reset, every control word, the GPU routing word and the PMU mask are zero. All `irq_o`/`fiq_o` lines stay low and all pending words read zero, even with every source asserted.
- R2: The timer control word of core c is at byte offset 0x40+4c. Bits [3:0] enable timers 0-3 onto IRQ and bits [7:4] enable them onto FIQ. When both bits of a timer are set, the timer goes to FIQ only. Timers occupy pending bits 0-3.
- R3: The mailbox control word of core c is at 0x50+4c and uses the same layout and the same FIQ precedence as R2. Mailboxes occupy pending bits 4-7.
- R4: The GPU routing word is at 0x0C. Bits [1:0] select the IRQ core, bits [3:2] select the FIQ core, bit 4 enables the IRQ path and bit 5 enables the FIQ path. The GPU occupies pending bit 8. When both paths are enabled and target the same core, only FIQ is raised there.
- R5: Writing 1 to bit n at 0x10 sets PMU enable n, and writing 1 to bit n at 0x14 clears it. Zero bits leave the mask unchanged. Both addresses read the mask in bits [3:0]. The PMU reaches IRQ-pending bit 9 of every enabled core and never reaches a FIQ word.
- R6: A read of offset 0x60+4c returns core c's IRQ-pending word, and a read of 0x70+4c returns its FIQ-pending word. The returned value is the one held before the read edge. Read data appears on `reg_rdata` at the clock edge that samples `reg_rd` and holds until the next read. Unmapped offsets read zero.
- R7: `irq_o[c]` is the OR of core c's IRQ-pending word and `fiq_o[c]` is the OR of its FIQ-pending word. Both update one clock after the source and configuration they depend on.
- R8: A source that is steered to FIQ on a core never appears in that core's IRQ-pending word.
- R9: Writes to the pending window 0x60-0x7F or to unmapped offsets change no configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte offset for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | DATA_W | Registered read data |
| tmr_src | input | NUM_CORES*4 | Timer levels, four per core, core c at [4c+3:4c] |
| mbx_src | input | NUM_CORES*4 | Mailbox levels, four per core, core c at [4c+3:4c] |
| gpu_src | input | 1 | Shared GPU interrupt level |
| pmu_src | input | 1 | Shared PMU interrupt level |
| irq_o | output | NUM_CORES | Per-core IRQ line |
| fiq_o | output | NUM_CORES | Per-core FIQ line |

## Verification
Two functions can fall in the same clock: a configuration write and a change on a source line, and a read of a pending word and the update of that same word. The random phase of the bench changes source levels, issues writes to the routing and enable words, and issues reads in the same cycles. A reference model compares every cycle. In that model, a write takes effect on the first edge after it, and a pending read returns the value held before its own edge. A design that forwards the new configuration or the new pending value early therefore shows a mismatch on `irq_o`, `fiq_o` or `reg_rdata`.

// File: rtl/core_irq_router_pkg.sv
`timescale 1ns/1ps
package core_irq_router_pkg;
  // sources per group (timers, mailboxes) per core
  localparam int GRP_W  = 4;
  localparam int CTRL_W = 2 * GRP_W;
  // pending word layout
  localparam int PEND_W = 10;
  localparam int PB_TMR = 0;
  localparam int PB_MBX = 4;
  localparam int PB_GPU = 8;
  localparam int PB_PMU = 9;
  // register window, byte offsets
  localparam int OFS_GPU_ROUTE = 'h0C;
  localparam int OFS_PMU_SET   = 'h10;
  localparam int OFS_PMU_CLR   = 'h14;
  localparam int OFS_TMR       = 'h40;
  localparam int OFS_MBX       = 'h50;
  localparam int OFS_IRQ_PEND  = 'h60;
  localparam int OFS_FIQ_PEND  = 'h70;
  localparam int STRIDE        = 4;

  typedef struct packed {
    logic       fiq_en;
    logic       irq_en;
    logic [1:0] fiq_core;
    logic [1:0] irq_core;
  } gpu_route_t;

  localparam int GPU_ROUTE_W = $bits(gpu_route_t);
endpackage

// File: rtl/core_irq_router_regs.sv
`timescale 1ns/1ps
module core_irq_router_regs
  import core_irq_router_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   wr_addr,
  input  logic [DATA_W-1:0]                   wr_data,
  output logic [NUM_CORES-1:0][CTRL_W-1:0]    tmr_ctrl,
  output logic [NUM_CORES-1:0][CTRL_W-1:0]    mbx_ctrl,
  output gpu_route_t                          gpu_route,
  output logic [NUM_CORES-1:0]                pmu_en
);
  localparam logic [ADDR_W-1:0] A_GPU     = ADDR_W'(OFS_GPU_ROUTE);
  localparam logic [ADDR_W-1:0] A_PMU_SET = ADDR_W'(OFS_PMU_SET);
  localparam logic [ADDR_W-1:0] A_PMU_CLR = ADDR_W'(OFS_PMU_CLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      gpu_route <= '0;
    end else if (wr_en && wr_addr == A_GPU) begin
      gpu_route <= gpu_route_t'(wr_data[GPU_ROUTE_W-1:0]);
    end
  end

  // set/clear pair: only the one bits of the write act
  always_ff @(posedge clk) begin
    if (rst) begin
      pmu_en <= '0;
    end else if (wr_en && wr_addr == A_PMU_SET) begin
      pmu_en <= pmu_en | wr_data[NUM_CORES-1:0];
    end else if (wr_en && wr_addr == A_PMU_CLR) begin
      pmu_en <= pmu_en & ~wr_data[NUM_CORES-1:0];
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    localparam logic [ADDR_W-1:0] A_TMR = ADDR_W'(OFS_TMR + STRIDE * c);
    localparam logic [ADDR_W-1:0] A_MBX = ADDR_W'(OFS_MBX + STRIDE * c);
    logic [CTRL_W-1:0] tmr_q;
    logic [CTRL_W-1:0] mbx_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        tmr_q <= '0;
        mbx_q <= '0;
      end else if (wr_en) begin
        if (wr_addr == A_TMR) tmr_q <= wr_data[CTRL_W-1:0];
        if (wr_addr == A_MBX) mbx_q <= wr_data[CTRL_W-1:0];
      end
    end

    assign tmr_ctrl[c] = tmr_q;
    assign mbx_ctrl[c] = mbx_q;
  end
endmodule

// File: rtl/core_irq_router_lane.sv
`timescale 1ns/1ps
module core_irq_router_lane
  import core_irq_router_pkg::*;
(
  input  logic [GRP_W-1:0]  tmr_src,
  input  logic [GRP_W-1:0]  mbx_src,
  input  logic [CTRL_W-1:0] tmr_ctrl,
  input  logic [CTRL_W-1:0] mbx_ctrl,
  input  logic              gpu_src,
  input  logic              gpu_to_irq,
  input  logic              gpu_to_fiq,
  input  logic              pmu_src,
  input  logic              pmu_en,
  output logic [PEND_W-1:0] irq_nxt,
  output logic [PEND_W-1:0] fiq_nxt
);
  // per-bit steering: fast enable wins over normal enable
  function automatic logic [2*GRP_W-1:0] steer(input logic [GRP_W-1:0]  src,
                                               input logic [CTRL_W-1:0] ctrl);
    logic [GRP_W-1:0] fast;
    logic [GRP_W-1:0] norm;
    fast = src & ctrl[CTRL_W-1:GRP_W];
    norm = src & ctrl[GRP_W-1:0] & ~ctrl[CTRL_W-1:GRP_W];
    return {fast, norm};
  endfunction

  logic [2*GRP_W-1:0] tmr_s;
  logic [2*GRP_W-1:0] mbx_s;

  always_comb begin
    tmr_s   = steer(tmr_src, tmr_ctrl);
    mbx_s   = steer(mbx_src, mbx_ctrl);
    irq_nxt = '0;
    fiq_nxt = '0;
    irq_nxt[PB_TMR +: GRP_W] = tmr_s[GRP_W-1:0];
    fiq_nxt[PB_TMR +: GRP_W] = tmr_s[2*GRP_W-1:GRP_W];
    irq_nxt[PB_MBX +: GRP_W] = mbx_s[GRP_W-1:0];
    fiq_nxt[PB_MBX +: GRP_W] = mbx_s[2*GRP_W-1:GRP_W];
    fiq_nxt[PB_GPU] = gpu_src & gpu_to_fiq;
    irq_nxt[PB_GPU] = gpu_src & gpu_to_irq & ~gpu_to_fiq;
    irq_nxt[PB_PMU] = pmu_src & pmu_en;
  end
endmodule

// File: rtl/core_irq_router_rdmux.sv
`timescale 1ns/1ps
module core_irq_router_rdmux
  import core_irq_router_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             rd_en,
  input  logic [ADDR_W-1:0]                rd_addr,
  input  logic [NUM_CORES-1:0][CTRL_W-1:0] tmr_ctrl,
  input  logic [NUM_CORES-1:0][CTRL_W-1:0] mbx_ctrl,
  input  gpu_route_t                       gpu_route,
  input  logic [NUM_CORES-1:0]             pmu_en,
  input  logic [NUM_CORES-1:0][PEND_W-1:0] irq_pend,
  input  logic [NUM_CORES-1:0][PEND_W-1:0] fiq_pend,
  output logic [DATA_W-1:0]                rd_data
);
  localparam logic [ADDR_W-1:0] A_GPU     = ADDR_W'(OFS_GPU_ROUTE);
  localparam logic [ADDR_W-1:0] A_PMU_SET = ADDR_W'(OFS_PMU_SET);
  localparam logic [ADDR_W-1:0] A_PMU_CLR = ADDR_W'(OFS_PMU_CLR);

  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (rd_addr == A_GPU) sel[GPU_ROUTE_W-1:0] = gpu_route;
    if (rd_addr == A_PMU_SET || rd_addr == A_PMU_CLR) sel[NUM_CORES-1:0] = pmu_en;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (rd_addr == ADDR_W'(OFS_TMR + STRIDE * c))      sel[CTRL_W-1:0] = tmr_ctrl[c];
      if (rd_addr == ADDR_W'(OFS_MBX + STRIDE * c))      sel[CTRL_W-1:0] = mbx_ctrl[c];
      if (rd_addr == ADDR_W'(OFS_IRQ_PEND + STRIDE * c)) sel[PEND_W-1:0] = irq_pend[c];
      if (rd_addr == ADDR_W'(OFS_FIQ_PEND + STRIDE * c)) sel[PEND_W-1:0] = fiq_pend[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= sel;
    end
  end
endmodule

// File: rtl/core_irq_router.sv
`timescale 1ns/1ps
module core_irq_router
  import core_irq_router_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic                       reg_wr,
  input  logic [DATA_W-1:0]          reg_wdata,
  input  logic                       reg_rd,
  output logic [DATA_W-1:0]          reg_rdata,
  input  logic [NUM_CORES*GRP_W-1:0] tmr_src,
  input  logic [NUM_CORES*GRP_W-1:0] mbx_src,
  input  logic                       gpu_src,
  input  logic                       pmu_src,
  output logic [NUM_CORES-1:0]       irq_o,
  output logic [NUM_CORES-1:0]       fiq_o
);
  logic [NUM_CORES-1:0][CTRL_W-1:0] tmr_ctrl;
  logic [NUM_CORES-1:0][CTRL_W-1:0] mbx_ctrl;
  gpu_route_t                       gpu_route;
  logic [NUM_CORES-1:0]             pmu_en;
  logic [NUM_CORES-1:0][PEND_W-1:0] irq_pend_nxt;
  logic [NUM_CORES-1:0][PEND_W-1:0] fiq_pend_nxt;
  logic [NUM_CORES-1:0][PEND_W-1:0] irq_pend_q;
  logic [NUM_CORES-1:0][PEND_W-1:0] fiq_pend_q;

  core_irq_router_regs #(
    .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(reg_wr), .wr_addr(reg_addr), .wr_data(reg_wdata),
    .tmr_ctrl(tmr_ctrl), .mbx_ctrl(mbx_ctrl),
    .gpu_route(gpu_route), .pmu_en(pmu_en)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_lane
    logic gpu_hit_irq;
    logic gpu_hit_fiq;
    assign gpu_hit_irq = gpu_route.irq_en && (gpu_route.irq_core == 2'(c));
    assign gpu_hit_fiq = gpu_route.fiq_en && (gpu_route.fiq_core == 2'(c));

    core_irq_router_lane u_lane (
      .tmr_src(tmr_src[c*GRP_W +: GRP_W]),
      .mbx_src(mbx_src[c*GRP_W +: GRP_W]),
      .tmr_ctrl(tmr_ctrl[c]),
      .mbx_ctrl(mbx_ctrl[c]),
      .gpu_src(gpu_src),
      .gpu_to_irq(gpu_hit_irq),
      .gpu_to_fiq(gpu_hit_fiq),
      .pmu_src(pmu_src),
      .pmu_en(pmu_en[c]),
      .irq_nxt(irq_pend_nxt[c]),
      .fiq_nxt(fiq_pend_nxt[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pend_q <= '0;
      fiq_pend_q <= '0;
      irq_o      <= '0;
      fiq_o      <= '0;
    end else begin
      irq_pend_q <= irq_pend_nxt;
      fiq_pend_q <= fiq_pend_nxt;
      for (int c = 0; c < NUM_CORES; c++) begin
        irq_o[c] <= |irq_pend_nxt[c];
        fiq_o[c] <= |fiq_pend_nxt[c];
      end
    end
  end

  core_irq_router_rdmux #(
    .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_rdmux (
    .clk(clk), .rst(rst),
    .rd_en(reg_rd), .rd_addr(reg_addr),
    .tmr_ctrl(tmr_ctrl), .mbx_ctrl(mbx_ctrl),
    .gpu_route(gpu_route), .pmu_en(pmu_en),
    .irq_pend(irq_pend_q), .fiq_pend(fiq_pend_q),
    .rd_data(reg_rdata)
  );
endmodule

// File: rtl/core_irq_router_chk.sv
`timescale 1ns/1ps
module core_irq_router_chk
  import core_irq_router_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             reg_wr,
  input logic [ADDR_W-1:0]                reg_addr,
  input logic [DATA_W-1:0]                reg_wdata,
  input logic [NUM_CORES-1:0]             pmu_en,
  input logic [NUM_CORES-1:0]             irq_o,
  input logic [NUM_CORES-1:0]             fiq_o,
  input logic [NUM_CORES-1:0][PEND_W-1:0] irq_pend_q,
  input logic [NUM_CORES-1:0][PEND_W-1:0] fiq_pend_q,
  input logic [NUM_CORES-1:0][CTRL_W-1:0] tmr_ctrl,
  input logic [NUM_CORES-1:0][CTRL_W-1:0] mbx_ctrl,
  input gpu_route_t                       gpu_route
);
  localparam logic [ADDR_W-1:0] A_PMU_CLR = ADDR_W'(OFS_PMU_CLR);
  localparam logic [ADDR_W-1:0] A_RO_LO   = ADDR_W'(OFS_IRQ_PEND);
  localparam logic [ADDR_W-1:0] A_RO_HI   = ADDR_W'(OFS_FIQ_PEND + STRIDE * NUM_CORES - 1);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (irq_o == '0 && fiq_o == '0 && pmu_en == '0));

  assert_pmu_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_PMU_CLR) |=> ((pmu_en & $past(reg_wdata[NUM_CORES-1:0])) == '0));

  assert_pend_write_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr >= A_RO_LO && reg_addr <= A_RO_HI)
      |=> ($stable(tmr_ctrl) && $stable(mbx_ctrl) && $stable(gpu_route) && $stable(pmu_en)));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assert_fiq_excludes_irq_R8: assert property (@(posedge clk) disable iff (rst)
      (irq_pend_q[c] & fiq_pend_q[c]) == '0);

    assert_line_is_or_R7: assert property (@(posedge clk) disable iff (rst)
      (irq_o[c] == (|irq_pend_q[c])) && (fiq_o[c] == (|fiq_pend_q[c])));

    assert_pmu_never_fast_R5: assert property (@(posedge clk) disable iff (rst)
      !fiq_pend_q[c][PB_PMU]);
  end
endmodule

bind core_irq_router core_irq_router_chk #(
  .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .pmu_en(pmu_en), .irq_o(irq_o), .fiq_o(fiq_o),
  .irq_pend_q(irq_pend_q), .fiq_pend_q(fiq_pend_q),
  .tmr_ctrl(tmr_ctrl), .mbx_ctrl(mbx_ctrl), .gpu_route(gpu_route)
);

// File: tb/core_irq_router_test.sv
`timescale 1ns/1ps
module core_irq_router_test;
  localparam int  NC   = 4;
  localparam int  AW   = 8;
  localparam int  DW   = 32;
  localparam time TCLK = 20ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic          reg_rd = 1'b0;
  logic [DW-1:0] reg_rdata;
  logic [NC*4-1:0] tmr_src = '0;
  logic [NC*4-1:0] mbx_src = '0;
  logic          gpu_src = 1'b0;
  logic          pmu_src = 1'b0;
  logic [NC-1:0] irq_o;
  logic [NC-1:0] fiq_o;

  always #(TCLK/2) clk = ~clk;

  core_irq_router #(.NUM_CORES(NC), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .tmr_src(tmr_src), .mbx_src(mbx_src), .gpu_src(gpu_src),
    .pmu_src(pmu_src), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_tmr [NC];
  int m_mbx [NC];
  int m_gpu;
  int m_pmu;
  int e_ip [NC];
  int e_fp [NC];
  logic [NC-1:0] e_irq;
  logic [NC-1:0] e_fiq;
  logic [31:0]   e_rd;

  function automatic int pend_of(input int c, input bit fast);
    int w;
    bit gf, gi;
    w = 0;
    for (int b = 0; b < 4; b++) begin
      if (tmr_src[c*4+b]) begin
        if ((m_tmr[c] >> (b+4)) & 1)   begin if (fast)  w |= 1 << b; end
        else if ((m_tmr[c] >> b) & 1)  begin if (!fast) w |= 1 << b; end
      end
      if (mbx_src[c*4+b]) begin
        if ((m_mbx[c] >> (b+4)) & 1)   begin if (fast)  w |= 1 << (b+4); end
        else if ((m_mbx[c] >> b) & 1)  begin if (!fast) w |= 1 << (b+4); end
      end
    end
    gf = (((m_gpu >> 5) & 1) == 1) && (((m_gpu >> 2) & 3) == c);
    gi = (((m_gpu >> 4) & 1) == 1) && ((m_gpu & 3) == c) && !gf;
    if (gpu_src && fast && gf)  w |= 1 << 8;
    if (gpu_src && !fast && gi) w |= 1 << 8;
    if (pmu_src && !fast && ((m_pmu >> c) & 1)) w |= 1 << 9;
    return w;
  endfunction

  function automatic logic [31:0] read_of(input int a);
    if (a == 'h0C) return 32'(m_gpu);
    if (a == 'h10 || a == 'h14) return 32'(m_pmu);
    for (int c = 0; c < NC; c++) begin
      if (a == 'h40 + 4*c) return 32'(m_tmr[c]);
      if (a == 'h50 + 4*c) return 32'(m_mbx[c]);
      if (a == 'h60 + 4*c) return 32'(e_ip[c]);
      if (a == 'h70 + 4*c) return 32'(e_fp[c]);
    end
    return 32'h0;
  endfunction

  always @(posedge clk) begin : model
    int n_ip [NC];
    int n_fp [NC];
    int a;
    if (rst) begin
      for (int c = 0; c < NC; c++) begin
        m_tmr[c] = 0; m_mbx[c] = 0; e_ip[c] = 0; e_fp[c] = 0;
      end
      m_gpu = 0; m_pmu = 0; e_irq = '0; e_fiq = '0; e_rd = '0;
    end else begin
      for (int c = 0; c < NC; c++) begin
        n_ip[c] = pend_of(c, 1'b0);
        n_fp[c] = pend_of(c, 1'b1);
      end
      a = int'(reg_addr);
      if (reg_rd) e_rd = read_of(a);
      if (reg_wr) begin
        if (a == 'h0C) m_gpu = int'(reg_wdata) & 'h3F;
        if (a == 'h10) m_pmu = m_pmu | (int'(reg_wdata) & 'hF);
        if (a == 'h14) m_pmu = m_pmu & ~(int'(reg_wdata) & 'hF);
        for (int c = 0; c < NC; c++) begin
          if (a == 'h40 + 4*c) m_tmr[c] = int'(reg_wdata) & 'hFF;
          if (a == 'h50 + 4*c) m_mbx[c] = int'(reg_wdata) & 'hFF;
        end
      end
      for (int c = 0; c < NC; c++) begin
        e_ip[c]  = n_ip[c];
        e_fp[c]  = n_fp[c];
        e_irq[c] = (n_ip[c] != 0);
        e_fiq[c] = (n_fp[c] != 0);
      end
    end
  end

  // every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R7 irq_o vs model", 32'(irq_o), 32'(e_irq));
      check("R7 fiq_o vs model", 32'(fiq_o), 32'(e_fiq));
      check("R6 reg_rdata vs model", reg_rdata, e_rd);
    end
  end

  // ---------------- drivers ----------------
  task automatic step();
    @(posedge clk);
    #2ns;
  endtask

  task automatic wr(input int a, input int d);
    reg_addr = AW'(a); reg_wdata = DW'(d); reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
    step();
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = AW'(a); reg_rd = 1'b1;
    step();
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  initial begin : watchdog
    #(TCLK * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] v;
    repeat (5) step();
    check("R1 irq_o in reset", 32'(irq_o), 32'h0);
    check("R1 fiq_o in reset", 32'(fiq_o), 32'h0);
    rst = 1'b0;
    // R1: all sources high, nothing enabled
    tmr_src = '1; mbx_src = '1; gpu_src = 1'b1; pmu_src = 1'b1;
    step(); step();
    check("R1 irq_o masked", 32'(irq_o), 32'h0);
    check("R1 fiq_o masked", 32'(fiq_o), 32'h0);
    rd('h60, v); check("R1 irq pend core0", v, 32'h0);
    rd('h44, v); check("R1 timer ctrl core1", v, 32'h0);
    // R2: core1 timers 0,1 to IRQ, timer1 also FIQ -> FIQ wins
    wr('h44, 'h23);
    rd('h64, v); check("R2 irq pend core1", v, 32'h001);
    rd('h74, v); check("R2 fiq pend core1", v, 32'h002);
    check("R2 irq_o", 32'(irq_o), 32'h2);
    check("R2 fiq_o", 32'(fiq_o), 32'h2);
    // R3: core2 mailboxes
    wr('h58, 'h23);
    rd('h68, v); check("R3 irq pend core2", v, 32'h010);
    rd('h78, v); check("R3 fiq pend core2", v, 32'h020);
    // R4: GPU steering
    wr('h0C, 'h13);
    rd('h6C, v); check("R4 gpu irq to core3", v, 32'h100);
    wr('h0C, 'h3F);
    rd('h6C, v); check("R4 R8 gpu irq suppressed core3", v, 32'h000);
    rd('h7C, v); check("R4 gpu fiq core3", v, 32'h100);
    wr('h0C, 'h24);
    rd('h74, v); check("R4 gpu fiq core1", v, 32'h102);
    rd('h7C, v); check("R4 core3 fiq released", v, 32'h000);
    rd('h0C, v); check("R4 route readback", v, 32'h24);
    // R5: PMU set/clear
    wr('h10, 'h5);
    rd('h10, v); check("R5 pmu mask after set", v, 32'h5);
    rd('h60, v); check("R5 pmu on core0", v, 32'h200);
    rd('h68, v); check("R5 pmu on core2", v, 32'h210);
    wr('h14, 'h1);
    rd('h14, v); check("R5 pmu mask after clear", v, 32'h4);
    rd('h60, v); check("R5 pmu off core0", v, 32'h000);
    wr('h10, 'h0);
    rd('h10, v); check("R5 zero set no effect", v, 32'h4);
    // R9: writes to pending and unmapped offsets ignored
    wr('h60, 'h3FF);
    wr('h30, 'hFF);
    rd('h44, v); check("R9 timer ctrl kept", v, 32'h23);
    rd('h10, v); check("R9 pmu mask kept", v, 32'h4);
    rd('h60, v); check("R9 pend core0 unchanged", v, 32'h000);
    rd('h30, v); check("R6 unmapped reads zero", v, 32'h0);
    // random phase: writes, reads and source changes in the same cycles
    for (int i = 0; i < 600; i++) begin
      int sel;
      tmr_src = 16'($urandom);
      mbx_src = 16'($urandom);
      gpu_src = 1'($urandom);
      pmu_src = 1'($urandom);
      reg_wr  = ($urandom % 3) == 0;
      sel = int'($urandom % 11);
      if (sel < 4)       reg_addr = AW'('h40 + 4*sel);
      else if (sel < 8)  reg_addr = AW'('h50 + 4*(sel-4));
      else if (sel == 8) reg_addr = AW'('h0C);
      else if (sel == 9) reg_addr = AW'('h10);
      else               reg_addr = AW'('h14);
      reg_wdata = $urandom;
      step();
      reg_wr = 1'b0;
      reg_rd = 1'b1;
      reg_addr = AW'(4 * ($urandom % 32));
      tmr_src = 16'($urandom);
      step();
      reg_rd = 1'b0;
    end
    step();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule